// File: doc/BRIEF.md
# Timeslot-Zero Word Sequencer

This block produces the eight-bit synchronisation word carried in timeslot zero of every frame on a primary-rate multiplex link. A frame counter steps through the sixteen frames of a multiframe. Odd-numbered frames get the fixed alignment pattern. Even-numbered frames get a service word that carries two alarm bits and four spare bits. The leading bit of every word is filled from a four-bit check value supplied by an external CRC calculator.

The surrounding framer pulses `frame_strobe` for one clock when a new frame begins. On that edge the counter moves to the next frame, and the word for that frame is built and registered. The word, the frame number and the multiframe-start flag then stay constant until the next strobe. The word is presented continuously and the downstream serialiser reads it whenever it needs it. There is no handshake and no back-pressure: the strobe alone decides when the block advances, and a serialiser that misses a frame simply sees the next one.

Top module: `ts0_seq`

## Requirements
- R1: After reset, `frame_num` is 1, `mf_start` is 1, and `word` is 8'h1B, meaning X=0 followed by the alignment pattern. The held check value is zero.
- R2: Each cycle with `frame_strobe` high advances `frame_num` by one, and frame 16 wraps to frame 1. The new value is visible after that clock edge. `frame_num` always lies in 1..16.
- R3: In odd frames, `word[6:0]` is 7'b0011011.
- R4: In even frames, `word[6]` is 1, `word[5]` equals `d_alarm`, `word[4]` equals `n_alarm`, and `word[3:0]` equals `y_spare`. All of these are sampled on the strobe that opens that frame.
- R5: Without a strobe, `word` and `frame_num` do not change, whatever the data inputs do.
- R6: `word[7]` is the X bit. Frames 2k-1 and 2k share one check bit. Within each half-multiframe (frames 1–8 and 9–16), successive frame pairs use `crc_bits[3]`, `crc_bits[2]`, `crc_bits[1]` and `crc_bits[0]`, in that order.
- R7: `crc_bits` is captured only on the strobes that open frame 1 and frame 9. A change at any other strobe has no effect on X until the next such capture.
- R8: `mf_start` is 1 exactly when `frame_num` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_strobe | input | 1 | One-cycle pulse marking the start of a frame |
| d_alarm | input | 1 | First alarm bit for service words |
| n_alarm | input | 1 | Second alarm bit for service words |
| y_spare | input | 4 | Spare service bits |
| crc_bits | input | 4 | Check value from the CRC calculator, bit 3 used first |
| word | output | 8 | Timeslot-zero word, bit 7 sent first |
| frame_num | output | 5 | Current frame number, 1..16 |
| mf_start | output | 1 | High during frame 1 |

## Verification
The assertions check the following on every cycle:
- the frame number stays in range and steps or wraps on each strobe;
- the word holds still between strobes;
- odd frames carry the alignment pattern;
- even frames carry the alarm and spare bits sampled at their opening strobe.

The order in which check bits are spread over the X positions depends on a value captured several frames earlier. Only the bench's scenarios show this ordering, and likewise the effect of changing the check value in the middle of a group. The reset word and the multiframe flag are also left to the bench.

// File: rtl/ts0_pkg.sv
package ts0_pkg;
  localparam int WORD_W = 8;
  localparam int SPARE_W = 4;
  localparam logic [WORD_W-2:0] ALIGN_TAIL = 7'b0011011;
endpackage

// File: rtl/ts0_frame_ctr.sv
module ts0_frame_ctr #(
  parameter int MF_FRAMES = 16,
  localparam int FW = $clog2(MF_FRAMES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [FW-1:0] cur_num,
  output logic [FW-1:0] nxt_num
);
  assign nxt_num = (cur_num == FW'(MF_FRAMES)) ? FW'(1) : cur_num + FW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cur_num <= FW'(1);
    else if (adv) cur_num <= nxt_num;
  end
endmodule

// File: rtl/ts0_crc_spread.sv
// Picks the X bit for the upcoming frame. A group of 2*CRC_BITS frames shares
// one captured check value; CRC_BITS must be a power of two.
module ts0_crc_spread #(
  parameter int MF_FRAMES = 16,
  parameter int CRC_BITS = 4,
  localparam int FW = $clog2(MF_FRAMES + 1),
  localparam int CW = $clog2(CRC_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                adv,
  input  logic [FW-1:0]       nxt_num,
  input  logic [CRC_BITS-1:0] crc_in,
  output logic                x_nxt
);
  logic [FW-1:0]       zero_based;
  logic [CW-1:0]       slot;
  logic                group_start;
  logic [CRC_BITS-1:0] held;

  assign zero_based  = nxt_num - FW'(1);
  assign slot        = CW'(zero_based >> 1);
  assign group_start = (slot == '0) && !zero_based[0];
  assign x_nxt       = group_start ? crc_in[CRC_BITS-1]
                                   : held[CW'(CRC_BITS - 1) - slot];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   held <= '0;
    else if (adv && group_start)  held <= crc_in;
  end
endmodule

// File: rtl/ts0_word_build.sv
module ts0_word_build
  import ts0_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               adv,
  input  logic               odd_nxt,
  input  logic               x_nxt,
  input  logic               d_in,
  input  logic               n_in,
  input  logic [SPARE_W-1:0] y_in,
  output logic [WORD_W-1:0]  word_q
);
  logic [WORD_W-1:0] word_d;

  always_comb begin
    if (odd_nxt) word_d = {x_nxt, ALIGN_TAIL};
    else         word_d = {x_nxt, 1'b1, d_in, n_in, y_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   word_q <= {1'b0, ALIGN_TAIL};
    else if (adv) word_q <= word_d;
  end
endmodule

// File: rtl/ts0_seq.sv
module ts0_seq
  import ts0_pkg::*;
#(
  parameter int MF_FRAMES = 16,
  parameter int CRC_BITS = 4,
  localparam int FW = $clog2(MF_FRAMES + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_strobe,
  input  logic                d_alarm,
  input  logic                n_alarm,
  input  logic [SPARE_W-1:0]  y_spare,
  input  logic [CRC_BITS-1:0] crc_bits,
  output logic [WORD_W-1:0]   word,
  output logic [FW-1:0]       frame_num,
  output logic                mf_start
);
  logic [FW-1:0] nxt_num;
  logic          x_nxt;

  ts0_frame_ctr #(.MF_FRAMES(MF_FRAMES)) u_ctr (
    .clk(clk), .rst_n(rst_n), .adv(frame_strobe),
    .cur_num(frame_num), .nxt_num(nxt_num)
  );

  ts0_crc_spread #(.MF_FRAMES(MF_FRAMES), .CRC_BITS(CRC_BITS)) u_spread (
    .clk(clk), .rst_n(rst_n), .adv(frame_strobe),
    .nxt_num(nxt_num), .crc_in(crc_bits), .x_nxt(x_nxt)
  );

  ts0_word_build u_build (
    .clk(clk), .rst_n(rst_n), .adv(frame_strobe),
    .odd_nxt(nxt_num[0]), .x_nxt(x_nxt),
    .d_in(d_alarm), .n_in(n_alarm), .y_in(y_spare),
    .word_q(word)
  );

  assign mf_start = (frame_num == FW'(1));
endmodule

// File: rtl/ts0_seq_chk.sv
module ts0_seq_chk #(
  parameter int MF_FRAMES = 16,
  localparam int FW = $clog2(MF_FRAMES + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_strobe,
  input logic          d_alarm,
  input logic          n_alarm,
  input logic [3:0]    y_spare,
  input logic [7:0]    word,
  input logic [FW-1:0] frame_num
);
  assert_frame_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_num >= FW'(1)) && (frame_num <= FW'(MF_FRAMES)));

  assert_frame_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_strobe |=> frame_num == (($past(frame_num) == FW'(MF_FRAMES)) ? FW'(1)
                                   : $past(frame_num) + FW'(1)));

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_strobe |=> ($stable(word) && $stable(frame_num)));

  assert_align_odd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_num[0] |-> (word[6:0] == 7'b0011011));

  assert_service_marker_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_num[0] |-> word[6]);

  assert_service_fields_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_strobe |=> (frame_num[0] ||
                      (word[5:0] == $past({d_alarm, n_alarm, y_spare}))));
endmodule

bind ts0_seq ts0_seq_chk #(.MF_FRAMES(MF_FRAMES)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_strobe(frame_strobe),
  .d_alarm(d_alarm), .n_alarm(n_alarm), .y_spare(y_spare),
  .word(word), .frame_num(frame_num)
);

// File: tb/ts0_seq_test.sv
module ts0_seq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_strobe = 1'b0;
  logic       d_alarm = 1'b0;
  logic       n_alarm = 1'b0;
  logic [3:0] y_spare = 4'h0;
  logic [3:0] crc_bits = 4'h0;
  logic [7:0] word;
  logic [4:0] frame_num;
  logic       mf_start;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;

  // Model state
  int         exp_frame = 1;
  logic [3:0] exp_held = 4'h0;
  logic [7:0] exp_word = 8'h1B;

  // {crc[3:0], d, n, y[3:0]} applied on successive strobes
  localparam logic [9:0] VEC [0:19] = '{
    10'b1011_1_0_1010, 10'b0110_0_1_0101, 10'b1111_1_1_1111, 10'b0000_0_0_0000,
    10'b1001_1_0_0011, 10'b0101_0_1_1100, 10'b1100_1_1_0110, 10'b0011_0_0_1001,
    10'b0110_1_0_0001, 10'b1111_0_1_1000, 10'b0000_1_1_0111, 10'b1010_0_0_1110,
    10'b1110_1_0_0100, 10'b0001_0_1_0010, 10'b1000_1_1_1011, 10'b0111_0_0_1101,
    10'b1101_1_0_0110, 10'b0010_0_1_1010, 10'b1011_1_1_0001, 10'b0100_0_0_1111
  };

  ts0_seq uut (
    .clk(clk), .rst_n(rst_n), .frame_strobe(frame_strobe),
    .d_alarm(d_alarm), .n_alarm(n_alarm), .y_spare(y_spare),
    .crc_bits(crc_bits), .word(word), .frame_num(frame_num), .mf_start(mf_start)
  );

  always #2 clk = ~clk;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string phase);
    check({"R2 frame ", phase}, {3'b0, frame_num}, 8'(exp_frame));
    check({"R8 mf_start ", phase}, {7'b0, mf_start}, {7'b0, exp_frame == 1});
    if (exp_frame % 2 == 1) check({"R3 align ", phase}, {1'b0, word[6:0]}, {1'b0, exp_word[6:0]});
    else                    check({"R4 service ", phase}, {1'b0, word[6:0]}, {1'b0, exp_word[6:0]});
    check({"R6 R7 x bit ", phase}, {7'b0, word[7]}, {7'b0, exp_word[7]});
  endtask

  // Model of one strobe, written from the requirements
  task automatic model_step(input logic [9:0] v);
    int slot;
    logic x;
    exp_frame = (exp_frame == 16) ? 1 : exp_frame + 1;
    slot = ((exp_frame - 1) / 2) % 4;
    if (exp_frame == 1 || exp_frame == 9) begin
      exp_held = v[9:6];
      x = v[9];
    end else begin
      x = exp_held[3 - slot];
    end
    if (exp_frame % 2 == 1) exp_word = {x, 7'b0011011};
    else                    exp_word = {x, 1'b1, v[5], v[4], v[3:0]};
  endtask

  task automatic strobe_with(input logic [9:0] v);
    @(negedge clk);
    {crc_bits, d_alarm, n_alarm, y_spare} = v;
    frame_strobe = 1'b1;
    @(negedge clk);
    frame_strobe = 1'b0;
    model_step(v);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset word", word, 8'h1B);
    check("R1 reset frame", {3'b0, frame_num}, 8'd1);
    check("R1 reset mf_start", {7'b0, mf_start}, 8'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("after release");

    // Table walk: more than one multiframe, wrap and both capture points
    for (int i = 0; i < 20; i++) begin
      strobe_with(VEC[i]);
      check_all("table");
      // R5: scramble inputs without a strobe; outputs must stay put
      {crc_bits, d_alarm, n_alarm, y_spare} = ~VEC[i];
      @(negedge clk);
      @(negedge clk);
      check("R5 idle word", word, exp_word);
      check("R5 idle frame", {3'b0, frame_num}, 8'(exp_frame));
    end

    // R7: check value changed mid-group has no effect; run to frame 1 then 9
    while (exp_frame != 16) strobe_with(10'b0000_0_0_0000);
    strobe_with(10'b1010_1_1_0000);   // frame 1 captures 1010
    check("R7 capture at frame 1", {7'b0, word[7]}, 8'd1);
    strobe_with(10'b0101_0_0_0000);   // frame 2 keeps bit 3 of 1010
    check("R7 pair shares bit", {7'b0, word[7]}, 8'd1);
    strobe_with(10'b1111_0_0_0000);   // frame 3 uses bit 2 of 1010
    check("R7 ignore mid-group crc", {7'b0, word[7]}, 8'd0);
    strobe_with(10'b1111_0_0_0000);   // frame 4
    strobe_with(10'b0000_0_0_0000);   // frame 5 uses bit 1 of 1010
    check("R6 third pair bit", {7'b0, word[7]}, 8'd1);
    check_all("directed");

    // R4: all-ones and all-zeros service fields
    strobe_with(10'b0000_1_1_1111);   // frame 6 even
    check("R4 fields ones", word[5:0], 8'h3F);
    strobe_with(10'b0000_0_0_0000);   // frame 7
    strobe_with(10'b0000_0_0_0000);   // frame 8 even
    check("R4 fields zeros", {2'b0, word[5:0]}, 8'h00);

    // R1: reset mid-run returns to frame 1 with X=0 and clears held value
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid-run reset word", word, 8'h1B);
    check("R1 mid-run reset frame", {3'b0, frame_num}, 8'd1);
    rst_n = 1'b1;
    exp_frame = 1; exp_held = 4'h0; exp_word = 8'h1B;
    strobe_with(10'b1111_1_0_0101);   // frame 2 uses cleared held value
    check("R1 held cleared", {7'b0, word[7]}, 8'd0);
    check_all("post reset");

    finish_run();
  end
endmodule